// File: doc/BRIEF.md
# On-Die Termination Value Controller

This block decides, cycle by cycle, which termination setting a DRAM die presents on its data pins. It takes the termination request pin and delays it through a fixed two-stage register pipeline. It reads a three-bit nominal termination code and a two-bit write termination code from the mode registers. It also receives a delay-locked-loop bypass flag, an output-disable mode bit, and a write command pulse with its write latency from the command scheduler. From the write command it builds a local write window. The window covers the four beats of the burst plus one guard cycle before and one after.

Two outputs report the result. A selector says whether termination is off, nominal, or using the write value. A value output carries the code that goes to the resistor network. While the window is open and termination is requested, the write value replaces the nominal one. This holds even when nominal termination is disabled. DLL-bypass mode suppresses dynamic switching. A separate registered enable drives the DQ/DQS output drivers from the output-disable bit. All pins are plain control signals with no handshake, because no data moves through the block.

Top module: `odt_term_ctrl`

## Requirements
- R1: While reset is asserted, term_sel is 0 (off), term_val is 0 and dq_oe is 0.
- R2: A change on odt_pin reaches the termination outputs after exactly two rising clock edges.
- R3: With the delayed request high, no write window open, and nom_code not zero, term_sel is 1 (nominal) and term_val equals nom_code.
- R4: With the delayed request low, term_sel is 0 and term_val is 0, whatever the codes and the write window are.
- R5: Count the edge that samples wr_cmd high as age 1, and number each later edge one higher. The write window is open at ages max(1, wr_lat-1) through wr_lat+4 inclusive.
- R6: With the request high, the window open, and wr_code not zero, term_sel is 2 (write) and term_val is {0, wr_code}.
- R7: Rule R6 applies even when nom_code is 0.
- R8: With wr_code equal to 0 the window has no effect: the outputs follow R3 or R4 and are off when nom_code is also 0.
- R9: When dll_off is high, term_sel is never 2. It is 1 only when the request is high and nom_code is not zero, and 0 otherwise.
- R10: dq_oe equals the inverse of out_dis as sampled at the previous edge. out_dis does not change term_sel.
- R11: A wr_cmd that arrives while a window is pending restarts the age at 1. Window timing then follows the new command only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| odt_pin | input | 1 | Termination request pin |
| nom_code | input | 3 | Nominal termination code, 0 = disabled |
| wr_code | input | 2 | Write termination code, 0 = disabled |
| wr_lat | input | 4 | Write latency in cycles |
| wr_cmd | input | 1 | One-cycle write command pulse |
| dll_off | input | 1 | DLL-bypass mode flag |
| out_dis | input | 1 | Output-disable mode bit |
| term_sel | output | 2 | 0 off, 1 nominal, 2 write |
| term_val | output | 3 | Applied termination code |
| dq_oe | output | 1 | DQ/DQS driver enable |

## Verification
The write window and DLL-bypass mode can both act in the same cycle. The bench provokes this by holding dll_off high while it issues a write command with a nonzero write code. It then checks that the selector shows nominal or off, and never the write value. The window edges and the output-disable path also overlap. The bench sweeps a write window cycle by cycle with the request held high, and separately toggles out_dis while nominal termination is active. In that case dq_oe must fall while term_sel stays at nominal.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    TERM_OFF = 2'd0,
    TERM_NOM = 2'd1,
    TERM_WR  = 2'd2
  } term_sel_e;
endpackage

// File: rtl/odt_req_pipe.sv
module odt_req_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stage_q;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/odt_wr_window.sv
module odt_wr_window #(
  parameter int LAT_W = 4,
  parameter int BURST = 4,
  parameter int GUARD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [LAT_W-1:0] wr_lat,
  output logic             win
);
  localparam int AGE_W = LAT_W + 3;

  logic [AGE_W-1:0] age_q;
  logic             busy_q;
  logic [AGE_W-1:0] lat_x;
  logic [AGE_W-1:0] last_age;

  assign lat_x    = AGE_W'(wr_lat);
  assign last_age = lat_x + AGE_W'(BURST + GUARD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q  <= '0;
      busy_q <= 1'b0;
    end else if (wr_cmd) begin
      age_q  <= AGE_W'(1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (age_q >= last_age) busy_q <= 1'b0;
      else                   age_q  <= age_q + AGE_W'(1);
    end
  end

  assign win = busy_q && ((age_q + AGE_W'(GUARD)) >= lat_x) && (age_q <= last_age);
endmodule

// File: rtl/odt_term_select.sv
module odt_term_select
  import odt_pkg::*;
#(
  parameter int NOM_W = 3,
  parameter int WR_W  = 2
) (
  input  logic             req,
  input  logic             win,
  input  logic             dll_off,
  input  logic [NOM_W-1:0] nom_code,
  input  logic [WR_W-1:0]  wr_code,
  output term_sel_e        sel,
  output logic [NOM_W-1:0] val
);
  logic nom_on, wr_on;

  assign nom_on = |nom_code;
  assign wr_on  = |wr_code;

  always_comb begin
    sel = TERM_OFF;
    val = '0;
    if (req) begin
      if (win && wr_on && !dll_off) begin
        sel = TERM_WR;
        val = NOM_W'(wr_code);
      end else if (nom_on) begin
        sel = TERM_NOM;
        val = nom_code;
      end
    end
  end
endmodule

// File: rtl/odt_term_ctrl.sv
module odt_term_ctrl
  import odt_pkg::*;
#(
  parameter int REQ_DLY = 2,
  parameter int LAT_W   = 4,
  parameter int BURST   = 4,
  parameter int GUARD   = 1,
  parameter int NOM_W   = 3,
  parameter int WR_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             odt_pin,
  input  logic [NOM_W-1:0] nom_code,
  input  logic [WR_W-1:0]  wr_code,
  input  logic [LAT_W-1:0] wr_lat,
  input  logic             wr_cmd,
  input  logic             dll_off,
  input  logic             out_dis,
  output logic [1:0]       term_sel,
  output logic [NOM_W-1:0] term_val,
  output logic             dq_oe
);
  logic      req_d;
  logic      win;
  term_sel_e sel;
  logic      oe_q;

  odt_req_pipe #(.DEPTH(REQ_DLY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din(odt_pin), .dout(req_d)
  );

  odt_wr_window #(.LAT_W(LAT_W), .BURST(BURST), .GUARD(GUARD)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_lat(wr_lat), .win(win)
  );

  odt_term_select #(.NOM_W(NOM_W), .WR_W(WR_W)) u_sel (
    .req(req_d), .win(win), .dll_off(dll_off),
    .nom_code(nom_code), .wr_code(wr_code), .sel(sel), .val(term_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= !out_dis;
  end

  assign term_sel = sel;
  assign dq_oe    = oe_q;
endmodule

// File: rtl/odt_term_ctrl_chk.sv
module odt_term_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       odt_pin,
  input logic [2:0] nom_code,
  input logic [1:0] wr_code,
  input logic       dll_off,
  input logic       out_dis,
  input logic [1:0] term_sel,
  input logic [2:0] term_val,
  input logic       dq_oe
);
  logic [1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              since_q <= 2'd0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  assert_req_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 2'd2 && !$past(odt_pin, 2)) |-> (term_sel == 2'd0));

  assert_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (term_sel == 2'd0) |-> (term_val == 3'd0));

  assert_nom_needs_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (term_sel == 2'd1) |-> (nom_code != 3'd0 && term_val == nom_code));

  assert_wr_needs_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_code == 2'd0) |-> (term_sel != 2'd2));

  assert_dll_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dll_off |-> (term_sel != 2'd2));

  assert_oe_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 2'd1) |-> (dq_oe == !$past(out_dis)));

  assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    term_sel != 2'd3);
endmodule

bind odt_term_ctrl odt_term_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .odt_pin(odt_pin), .nom_code(nom_code),
  .wr_code(wr_code), .dll_off(dll_off), .out_dis(out_dis),
  .term_sel(term_sel), .term_val(term_val), .dq_oe(dq_oe)
);

// File: tb/odt_term_ctrl_tb.sv
module odt_term_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       odt_pin;
  logic [2:0] nom_code;
  logic [1:0] wr_code;
  logic [3:0] wr_lat;
  logic       wr_cmd;
  logic       dll_off;
  logic       out_dis;
  logic [1:0] term_sel;
  logic [2:0] term_val;
  logic       dq_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  odt_term_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .odt_pin(odt_pin), .nom_code(nom_code),
    .wr_code(wr_code), .wr_lat(wr_lat), .wr_cmd(wr_cmd), .dll_off(dll_off),
    .out_dis(out_dis), .term_sel(term_sel), .term_val(term_val), .dq_oe(dq_oe)
  );

  // {dll_off, odt, nom[2:0], wr[1:0], open_window, expected_sel[1:0]}
  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd5, 2'd0, 1'b0, 2'd1},  // R3 nominal
    {1'b0, 1'b0, 3'd5, 2'd2, 1'b0, 2'd0},  // R4 request low
    {1'b0, 1'b1, 3'd5, 2'd2, 1'b1, 2'd2},  // R6 write replaces nominal
    {1'b0, 1'b1, 3'd0, 2'd3, 1'b1, 2'd2},  // R7 write with nominal off
    {1'b0, 1'b1, 3'd3, 2'd0, 1'b1, 2'd1},  // R8 write code zero
    {1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 2'd0},  // R8 both codes zero
    {1'b1, 1'b1, 3'd4, 2'd2, 1'b1, 2'd1},  // R9 bypass keeps nominal
    {1'b1, 1'b1, 3'd0, 2'd2, 1'b1, 2'd0},  // R9 bypass, nominal off
    {1'b0, 1'b0, 3'd6, 2'd1, 1'b1, 2'd0}   // R4 window without request
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_val(input int sel, input int nom, input int wr);
    if (sel == 1) return nom;
    if (sel == 2) return wr;
    return 0;
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; odt_pin = 1'b1; nom_code = 3'd5; wr_code = 2'd2;
    wr_lat = 4'd2; wr_cmd = 1'b0; dll_off = 1'b0; out_dis = 1'b0;
    step(); step();
    chk("R1 sel", int'(term_sel), 0);
    chk("R1 val", int'(term_val), 0);
    chk("R1 oe", int'(dq_oe), 0);
    odt_pin = 1'b0;
    rst_n = 1'b1;
    step(); step(); step();
    chk("R10 oe after reset", int'(dq_oe), 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [9:0] e;
      e = VEC[v];
      dll_off = e[9]; odt_pin = e[8]; nom_code = e[7:5]; wr_code = e[4:3];
      wr_lat = 4'd2;
      step(); step(); step();
      if (e[2]) begin
        wr_cmd = 1'b1;
        step();
        wr_cmd = 1'b0;
      end
      chk($sformatf("R3-table vec%0d sel", v), int'(term_sel), int'(e[1:0]));
      chk($sformatf("R6 vec%0d val", v), int'(term_val),
          exp_val(int'(e[1:0]), int'(e[7:5]), int'(e[4:3])));
      odt_pin = 1'b0; dll_off = 1'b0;
      for (int k = 0; k < 9; k++) step();
    end

    // R2 pipeline delay
    nom_code = 3'd4; wr_code = 2'd1; odt_pin = 1'b1;
    step();
    chk("R2 one edge", int'(term_sel), 0);
    step();
    chk("R2 two edges", int'(term_sel), 1);
    odt_pin = 1'b0;
    step();
    chk("R2 fall one edge", int'(term_sel), 1);
    step();
    chk("R2 fall two edges", int'(term_sel), 0);

    // R5 window sweep, latency 5
    odt_pin = 1'b1; wr_lat = 4'd5;
    step(); step(); step();
    wr_cmd = 1'b1;
    step();
    wr_cmd = 1'b0;
    for (int j = 1; j <= 11; j++) begin
      chk($sformatf("R5 age %0d", j), int'(term_sel), (j >= 4 && j <= 9) ? 2 : 1);
      step();
    end

    // R11 restart, latency 3: window at ages 2..7
    wr_lat = 4'd3;
    wr_cmd = 1'b1;
    step();
    wr_cmd = 1'b0;
    step(); step(); step();
    chk("R11 first window open", int'(term_sel), 2);
    wr_cmd = 1'b1;
    step();
    wr_cmd = 1'b0;
    chk("R11 restart age1", int'(term_sel), 1);
    for (int j = 2; j <= 8; j++) begin
      step();
      chk($sformatf("R11 age %0d", j), int'(term_sel), (j <= 7) ? 2 : 1);
    end

    // R10 output disable, independent of termination
    out_dis = 1'b1;
    step();
    chk("R10 oe low", int'(dq_oe), 0);
    chk("R10 sel unaffected", int'(term_sel), 1);
    out_dis = 1'b0;
    step();
    chk("R10 oe restored", int'(dq_oe), 1);

    // R9 bypass overlapping write window
    dll_off = 1'b1; wr_lat = 4'd2; wr_code = 2'd3;
    wr_cmd = 1'b1;
    step();
    wr_cmd = 1'b0;
    chk("R9 window under bypass", int'(term_sel), 1);
    chk("R9 val under bypass", int'(term_val), 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule